// File: doc/BRIEF.md
# Codec Path and Volume Control Port

This block is the write-only control port that a host microcontroller uses to set up the voice codec's signal paths. The host drives three wires: an active-low frame enable, a serial data clock and a data line. While the frame enable is low, each rising edge of the data clock shifts one bit into an eight-bit shift register, most significant bit first. When the enable returns high, the eight bits held in the shift register are copied into the control register in a single step.

The control register is decoded into the codec's digital path controls: a two-bit transmit input select (mute, microphone, handset or sum of both) with a separate sum flag, two receive routing enables (one for the differential driver and one for the auxiliary output), and a three-bit volume step with the matching attenuation in dB. An active-low power-down input forces the register back to its defaults. All three serial wires are asynchronous to the system clock. They are synchronised and edge-detected inside the block.

Top module: `codec_ctl_port`

## Requirements
- R1: While `ser_en` is low, each rising edge of `ser_clk` shifts `ser_dat` into the shift register. A rising edge of `ser_en` copies the shift register into the control register. Nothing shifted so far reaches the outputs before that edge.
- R2: The first bit shifted in lands in register bit 7 and the last in bit 0. Bit 7 is transmit switch A, bit 6 is transmit switch B, bit 5 is the driver route bit, bit 4 is the auxiliary route bit, bit 3 is ignored, and bits 2..0 are the volume step with bit 2 as its MSB.
- R3: `tx_sel` = {bit 6, bit 7}. Code 0 mutes, 1 selects the microphone, 2 selects the handset and 3 selects the sum of both inputs. `tx_sum` is 1 exactly when `tx_sel` is 3.
- R4: `vol_step` = bits 2..0 and `atten_db` = 4 × `vol_step`, so codes 0 through 7 give 0 through 28 dB of attenuation.
- R5: While `pd_n` is low, the control register is held at all zeros and enable edges commit nothing. After `pd_n` returns high, the zeros remain until the next commit.
- R6: `drv_route_en` equals bit 5 and `aux_route_en` equals bit 4. A value of 1 routes the converter output and 0 selects the idle level.
- R7: Every falling edge of `ser_en` clears the shift register. A frame of fewer than 8 clocks therefore commits its bits in the low positions with zeros above them. A frame of more than 8 clocks commits its last 8 bits.
- R8: Rising edges of `ser_clk` while `ser_en` is high have no effect on the outputs.
- R9: All decoded outputs change together, and only on the system clock cycle after a commit, or as a result of power-down or reset.
- R10: Synchronous active-high `rst` sets every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Power-down, active low, forces register defaults |
| ser_clk | input | 1 | Serial data clock, asynchronous |
| ser_en | input | 1 | Frame enable, active low, commit on rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| tx_sel | output | 2 | Transmit input select: 0 mute, 1 mic, 2 handset, 3 sum |
| tx_sum | output | 1 | High when both transmit inputs are summed |
| drv_route_en | output | 1 | Differential driver takes converter output |
| aux_route_en | output | 1 | Auxiliary output takes converter output |
| vol_step | output | 3 | Receive volume step index |
| atten_db | output | ATTEN_W | Receive attenuation in dB (4 per step) |

## Verification
The hardest cases to create from the ports are a frame that ends with too few or too many clocks, and a fully shifted frame observed before its enable edge. In both, the block's state differs from anything a clean eight-bit write leaves behind. The stimulus drives frames of three and ten clocks and checks which bits land. It also holds the enable low after eight clocks to show that the outputs keep the previous value. Stray clocks with the enable high, and writes attempted during power-down, are shown to leave the decoded outputs untouched.

// File: rtl/cctl_pkg.sv
`timescale 1ns/1ps
package cctl_pkg;

    localparam int CTRL_W   = 8;
    localparam int VOL_W    = 3;
    localparam int POS_TXA  = 7;
    localparam int POS_TXB  = 6;
    localparam int POS_DRV  = 5;
    localparam int POS_AUX  = 4;
    localparam int POS_VOLH = 2;

    localparam logic [CTRL_W-1:0] CTRL_DEFAULT = '0;

    typedef enum logic [1:0] {
        TX_MUTE    = 2'd0,
        TX_MIC     = 2'd1,
        TX_HANDSET = 2'd2,
        TX_BOTH    = 2'd3
    } tx_path_e;

    typedef struct packed {
        tx_path_e         tx;
        logic             drv_en;
        logic             aux_en;
        logic [VOL_W-1:0] step;
    } path_cfg_t;

    function automatic path_cfg_t unpack_ctrl(input logic [CTRL_W-1:0] r);
        path_cfg_t c;
        c.tx     = tx_path_e'({r[POS_TXB], r[POS_TXA]});
        c.drv_en = r[POS_DRV];
        c.aux_en = r[POS_AUX];
        c.step   = r[POS_VOLH -: VOL_W];
        return c;
    endfunction

endpackage

// File: rtl/cctl_sync.sv
`timescale 1ns/1ps
module cctl_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cctl_shifter.sv
`timescale 1ns/1ps
module cctl_shifter
    import cctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic              sclk_lvl,
    input  logic              sen_lvl,
    input  logic              sdat_lvl,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              commit
);
    logic              sclk_d;
    logic              sen_d;
    logic [CTRL_W-1:0] shreg;
    logic              sclk_rise;
    logic              sen_rise;
    logic              sen_fall;

    assign sclk_rise = sclk_lvl & ~sclk_d;
    assign sen_rise  = sen_lvl & ~sen_d;
    assign sen_fall  = ~sen_lvl & sen_d;
    assign commit    = sen_rise & pd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            sen_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_lvl;
            sen_d  <= sen_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pd_n) begin
            shreg  <= '0;
            ctrl_q <= CTRL_DEFAULT;
        end else begin
            if (sen_fall)
                shreg <= '0;
            else if (sclk_rise && !sen_lvl)
                shreg <= {shreg[CTRL_W-2:0], sdat_lvl};
            if (sen_rise)
                ctrl_q <= shreg;
        end
    end
endmodule

// File: rtl/cctl_decode.sv
`timescale 1ns/1ps
module cctl_decode
    import cctl_pkg::*;
#(
    parameter int STEP_DB = 4,
    parameter int ATTEN_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CTRL_W-1:0]  ctrl,
    output path_cfg_t          cfg_q,
    output logic [ATTEN_W-1:0] atten_q
);
    path_cfg_t          cfg_d;
    logic [ATTEN_W-1:0] atten_d;

    always_comb begin
        cfg_d   = unpack_ctrl(ctrl);
        atten_d = ATTEN_W'(32'(cfg_d.step) * STEP_DB);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= unpack_ctrl(CTRL_DEFAULT);
            atten_q <= '0;
        end else begin
            cfg_q   <= cfg_d;
            atten_q <= atten_d;
        end
    end
endmodule

// File: rtl/codec_ctl_port.sv
`timescale 1ns/1ps
module codec_ctl_port
    import cctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STEP_DB     = 4,
    parameter int ATTEN_W     = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pd_n,
    input  logic               ser_clk,
    input  logic               ser_en,
    input  logic               ser_dat,
    output logic [1:0]         tx_sel,
    output logic               tx_sum,
    output logic               drv_route_en,
    output logic               aux_route_en,
    output logic [VOL_W-1:0]   vol_step,
    output logic [ATTEN_W-1:0] atten_db
);
    localparam logic [2:0] SYNC_RST = 3'b010;

    logic [2:0]        raw;
    logic [2:0]        lvl;
    logic [CTRL_W-1:0] ctrl_q;
    logic              commit_w;
    path_cfg_t         cfg;

    assign raw = {ser_clk, ser_en, ser_dat};

    cctl_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (lvl)
    );

    cctl_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .pd_n     (pd_n),
        .sclk_lvl (lvl[2]),
        .sen_lvl  (lvl[1]),
        .sdat_lvl (lvl[0]),
        .ctrl_q   (ctrl_q),
        .commit   (commit_w)
    );

    cctl_decode #(.STEP_DB(STEP_DB), .ATTEN_W(ATTEN_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl_q),
        .cfg_q   (cfg),
        .atten_q (atten_db)
    );

    assign tx_sel       = cfg.tx;
    assign tx_sum       = (cfg.tx == TX_BOTH);
    assign drv_route_en = cfg.drv_en;
    assign aux_route_en = cfg.aux_en;
    assign vol_step     = cfg.step;
endmodule

// File: rtl/codec_ctl_port_chk.sv
`timescale 1ns/1ps
module codec_ctl_port_chk #(
    parameter int STEP_DB = 4,
    parameter int ATTEN_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               pd_n,
    input logic               commit,
    input logic [1:0]         tx_sel,
    input logic               tx_sum,
    input logic               drv_route_en,
    input logic               aux_route_en,
    input logic [2:0]         vol_step,
    input logic [ATTEN_W-1:0] atten_db
);
    // R5: two cycles after power-down is sampled low, outputs are at defaults
    p_pd_defaults_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!pd_n, 2) |-> (tx_sel == 2'd0 && !drv_route_en && !aux_route_en && vol_step == 3'd0));

    // R9: a change on any decoded output is preceded by a commit, power-down or reset
    p_change_after_commit_r9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tx_sel) || !$stable(vol_step) || !$stable(drv_route_en) || !$stable(aux_route_en))
        |-> ($past(commit, 2) || $past(!pd_n, 2) || $past(rst, 2)));

    // R3: sum flag only with the summed transmit path
    p_sum_flag_r3: assert property (@(posedge clk) disable iff (rst)
        tx_sum == (tx_sel == 2'd3));

    // R4: attenuation tracks the step index
    p_atten_scale_r4: assert property (@(posedge clk) disable iff (rst)
        atten_db == ATTEN_W'(32'(vol_step) * STEP_DB));

    // R10: reset drives outputs to zero on the next cycle
    p_reset_zero_r10: assert property (@(posedge clk)
        rst |=> (tx_sel == 2'd0 && !tx_sum && !drv_route_en && !aux_route_en && atten_db == '0));
endmodule

bind codec_ctl_port codec_ctl_port_chk #(.STEP_DB(STEP_DB), .ATTEN_W(ATTEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pd_n         (pd_n),
    .commit       (commit_w),
    .tx_sel       (tx_sel),
    .tx_sum       (tx_sum),
    .drv_route_en (drv_route_en),
    .aux_route_en (aux_route_en),
    .vol_step     (vol_step),
    .atten_db     (atten_db)
);

// File: tb/codec_ctl_port_tb.sv
`timescale 1ns/1ps
module codec_ctl_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_en = 1'b1;
    logic       ser_dat = 1'b0;
    logic [1:0] tx_sel;
    logic       tx_sum;
    logic       drv_route_en;
    logic       aux_route_en;
    logic [2:0] vol_step;
    logic [4:0] atten_db;
    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    codec_ctl_port u_dut (
        .clk(clk), .rst(rst), .pd_n(pd_n),
        .ser_clk(ser_clk), .ser_en(ser_en), .ser_dat(ser_dat),
        .tx_sel(tx_sel), .tx_sum(tx_sum),
        .drv_route_en(drv_route_en), .aux_route_en(aux_route_en),
        .vol_step(vol_step), .atten_db(atten_db)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // expected decode of a committed register value
    task automatic expect_reg(input string tag, input logic [7:0] v);
        chk({tag, " tx_sel R3"}, int'(tx_sel), int'({v[6], v[7]}));
        chk({tag, " tx_sum R3"}, int'(tx_sum), int'(v[7] & v[6]));
        chk({tag, " drv R6"}, int'(drv_route_en), int'(v[5]));
        chk({tag, " aux R6"}, int'(aux_route_en), int'(v[4]));
        chk({tag, " step R4"}, int'(vol_step), int'(v[2:0]));
        chk({tag, " atten R4"}, int'(atten_db), 4 * int'(v[2:0]));
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            tick(4);
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
        end
        tick(4);
    endtask

    task automatic send(input logic [15:0] bits, input int n);
        ser_en = 1'b0;
        tick(6);
        shift_bits(bits, n);
        ser_en = 1'b1;
        tick(10);
    endtask

    task automatic t_reset;
        tick(4);
        rst = 1'b0;
        tick(4);
        expect_reg("R10 after reset", 8'h00);
    endtask

    task automatic t_basic_writes;
        send(16'hB5, 8); expect_reg("R1 R2 mic 0xB5", 8'hB5);
        send(16'h40, 8); expect_reg("R2 handset 0x40", 8'h40);
        send(16'hC7, 8); expect_reg("R3 sum 0xC7", 8'hC7);
        send(16'h08, 8); expect_reg("R2 unused bit3", 8'h00);
    endtask

    task automatic t_vol_sweep;
        for (int s = 0; s < 8; s++) begin
            send(16'(s | 8'h10), 8);
            expect_reg("R4 sweep", 8'(s | 8'h10));
        end
    endtask

    task automatic t_hold_until_edge;
        send(16'hC7, 8);
        ser_en = 1'b0;
        tick(6);
        shift_bits(16'h00, 8);
        tick(10);
        expect_reg("R9 R1 before enable edge", 8'hC7);
        ser_en = 1'b1;
        tick(10);
        expect_reg("R9 after enable edge", 8'h00);
    endtask

    task automatic t_short_long;
        send(16'hFF, 8);
        send(16'b101, 3);
        expect_reg("R7 short frame", 8'h05);
        send(16'b11_1000_0011, 10);
        expect_reg("R7 long frame", 8'h83);
    endtask

    task automatic t_idle_clocks;
        send(16'h87, 8);
        ser_dat = 1'b1;
        for (int k = 0; k < 5; k++) begin
            ser_clk = 1'b1; tick(4);
            ser_clk = 1'b0; tick(4);
        end
        tick(10);
        expect_reg("R8 idle clocks", 8'h87);
    endtask

    task automatic t_power_down;
        send(16'hFF, 8);
        expect_reg("R5 pre", 8'hFF);
        pd_n = 1'b0;
        tick(6);
        expect_reg("R5 during power-down", 8'h00);
        send(16'hFF, 8);
        expect_reg("R5 write blocked", 8'h00);
        pd_n = 1'b1;
        tick(10);
        expect_reg("R5 kept after release", 8'h00);
        send(16'h3A, 8);
        expect_reg("R5 new write", 8'h3A);
    endtask

    task automatic t_sync_reset;
        send(16'hF6, 8);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        expect_reg("R10 mid-run reset", 8'h00);
    endtask

    initial begin
        t_reset();
        t_basic_writes();
        t_vol_sweep();
        t_hold_until_edge();
        t_short_long();
        t_idle_clocks();
        t_power_down();
        t_sync_reset();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule